// File: doc/BRIEF.md
# E1 Per-Timeslot Transmit Payload Conditioner

This block sits in an E1 transmit path, after the framer has laid out the outgoing bit stream and before line coding. It takes one bit per clock, together with the bit's timeslot number and its position inside the timeslot. A small per-timeslot table tells it how to alter that bit. Depending on the table and a few global controls, the bit is sent unchanged, copied to a test pattern detector, replaced by a loopback stream, a digital milliwatt byte, a generator pattern or a stored idle byte, or partly inverted.

The outgoing ABCD signaling nibble that goes with each timeslot can also be replaced by a stored per-timeslot nibble. All outputs are registered and appear one clock after the bit they belong to. A built-in frame phase counter steps the milliwatt sequences one byte per frame.

Each table entry is written whole through a simple write port. The host loads the table and sets the global enable, the direction and the framed/unframed controls as static configuration.

Top module: `e1_tx_payload_cond`

## Requirements
- R1: Synchronous active-low reset clears `tx_bit_o`, `sig_o`, `tap_vld_o`, `tap_bit_o`, the milliwatt frame phase and every table entry to zero. A cleared entry leaves its timeslot unaltered.
- R2: While `pc_en_i` is 0, `tx_bit_o` equals `tx_bit_i`, `sig_o` equals `sig_i` and `tap_vld_o` is 0, whatever the table holds.
- R3: With `pc_en_i`=1 and `dir_extract_i`=1, a bit is tapped when `unf_det_i`=1 (any timeslot, test bit ignored) or when its entry's test bit is 1. A tapped bit gives `tap_vld_o`=1 and `tap_bit_o`=`tx_bit_i`, and it leaves `tx_bit_o`=`tx_bit_i` with every lower action suppressed. Tapping is the highest-priority action.
- R4: Next in priority, an entry with the loop bit set sends `loop_bit_i` as `tx_bit_o`.
- R5: Next, an entry with subs=1 and code_a=1 sends a milliwatt byte. With code_b=1 the byte comes from the A-law cycle 34,21,21,34,B4,A1,A1,B4 (hex). With code_b=0 it comes from the µ-law cycle 1E,0B,0B,1E,9E,8B,8B,9E (hex). The byte is chosen by the frame phase. `bit_idx_i`=0 is the MSB of the byte.
- R6: Next, with `dir_extract_i`=0, a bit is replaced by `pat_bit_i` when `unf_gen_i`=1 (all timeslots, test bit ignored) or when its entry's test bit is 1.
- R7: Next, an entry with subs=1 and code_a=0 sends its stored idle byte, MSB first.
- R8: Lowest, an entry with subs=0 inverts bits according to {code_a,code_b}. 01 inverts the odd bits, 10 the even bits and 11 all bits. Bits are counted from 1 at `bit_idx_i`=0, so the odd bits are at even `bit_idx_i`. Code 00 leaves the bit unchanged.
- R9: With `pc_en_i`=1, `cas_en_i`=1 and the entry's sigsrc bit set, `sig_o` is the stored ABCD nibble. Otherwise `sig_o` is `sig_i`.
- R10: Outputs are registered and reflect the inputs of the previous clock. The frame phase advances by one, modulo 8, after the bit with timeslot 31 and `bit_idx_i`=7.
- R11: `cfg_wdata_i` is laid out as [17:14] ABCD, [13:6] idle byte, [5] subs, [4] code_a, [3] code_b, [2] test, [1] loop, [0] sigsrc. A write at a clock edge applies to bits presented after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_en_i | input | 1 | Global enable for per-timeslot conditioning |
| dir_extract_i | input | 1 | 1: tap toward detector, 0: insert generator pattern |
| unf_det_i | input | 1 | Tap every timeslot, ignoring test bits |
| unf_gen_i | input | 1 | Insert pattern in every timeslot, ignoring test bits |
| cas_en_i | input | 1 | Channel-associated signaling in use |
| cfg_we_i | input | 1 | Table entry write strobe |
| cfg_ts_i | input | 5 | Timeslot of the entry written |
| cfg_wdata_i | input | 18 | Entry contents (layout in R11) |
| ts_idx_i | input | 5 | Timeslot of the current bit |
| bit_idx_i | input | 3 | Position of the current bit, 0 = MSB |
| tx_bit_i | input | 1 | Outgoing data bit from the framer |
| loop_bit_i | input | 1 | Loopback data bit |
| pat_bit_i | input | 1 | Generator pattern bit |
| sig_i | input | 4 | Outgoing ABCD nibble for this timeslot |
| tx_bit_o | output | 1 | Conditioned data bit |
| sig_o | output | 4 | Conditioned ABCD nibble |
| tap_vld_o | output | 1 | Tap bit valid toward detector |
| tap_bit_o | output | 1 | Tapped data bit |

## Verification
The bench targets the places where actions collide. One is a timeslot with loop, milliwatt and test bits set together under both directions. A design with a wrong priority order would send the generator pattern or the idle byte where loopback or milliwatt should win. Unframed runs with random test bits catch a design that still honours the per-timeslot test bit. Nine-frame milliwatt runs across the frame wrap, with code_b varied per timeslot, catch a phase counter that steps at the wrong bit or a swapped A-law/µ-law table. Mid-stream table writes and inversion codes at every bit position catch a write that lands one bit late and odd/even bit numbering that is off by one.

// File: rtl/e1pc_pkg.sv
// Shared types and constants of the E1 transmit payload conditioner.
// Assumes 8-bit timeslots and a 4-bit ABCD signaling nibble.
package e1pc_pkg;
    localparam int SLOT_W  = 8;
    localparam int SIG_W   = 4;
    localparam int MW_LEN  = 8;
    localparam int PH_W    = $clog2(MW_LEN);
    localparam int POS_W   = $clog2(SLOT_W);

    // One table entry; packed order matches the write data layout.
    typedef struct packed {
        logic [SIG_W-1:0]  abcd;
        logic [SLOT_W-1:0] idle;
        logic              subs;
        logic              code_a;
        logic              code_b;
        logic              test;
        logic              loop;
        logic              sigsrc;
    } ts_cfg_t;

    localparam int CFG_W = $bits(ts_cfg_t);

    typedef enum logic [2:0] {
        ACT_PASS, ACT_TAP, ACT_LOOP, ACT_MW, ACT_PAT, ACT_IDLE, ACT_INV
    } act_e;

    // Milliwatt byte for a given law (1 = A-law) and frame phase.
    function automatic logic [SLOT_W-1:0] mw_byte(input logic alaw, input logic [PH_W-1:0] ph);
        logic [SLOT_W-1:0] b;
        case (ph[1:0])
            2'd0, 2'd3: b = alaw ? 8'h34 : 8'h1E;
            default:    b = alaw ? 8'h21 : 8'h0B;
        endcase
        if (ph[2]) b = alaw ? (b | 8'h80) : (b | 8'h80);
        return b;
    endfunction
endpackage

// File: rtl/e1pc_cfg_store.sv
// Per-timeslot configuration table: one whole-entry write port and one
// asynchronous read port addressed by the current timeslot.
// Assumes writes and reads of the same entry in one cycle see the old value.
module e1pc_cfg_store
    import e1pc_pkg::*;
#(
    parameter int N_TS = 32,
    localparam int TS_W = $clog2(N_TS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [TS_W-1:0] wa,
    input  ts_cfg_t         wd,
    input  logic [TS_W-1:0] ra,
    output ts_cfg_t         rd
);
    ts_cfg_t mem [N_TS];

    // Clear all entries on reset, otherwise store the written entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_TS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wa] <= wd;
        end
    end

    // Read the entry of the current timeslot.
    always_comb rd = mem[ra];
endmodule

// File: rtl/e1pc_frame_phase.sv
// Frame phase counter for the milliwatt sequences: steps once per frame,
// after the last bit of the last timeslot.
// Assumes every clock carries exactly one bit of the frame.
module e1pc_frame_phase
    import e1pc_pkg::*;
#(
    parameter int N_TS = 32,
    localparam int TS_W = $clog2(N_TS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TS_W-1:0]  ts_idx,
    input  logic [POS_W-1:0] bit_idx,
    output logic [PH_W-1:0]  phase
);
    logic frame_end;

    // Detect the final bit of the frame.
    always_comb frame_end = (ts_idx == TS_W'(N_TS - 1)) && (bit_idx == POS_W'(SLOT_W - 1));

    // Advance the phase at each frame end, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)         phase <= '0;
        else if (frame_end) phase <= phase + 1'b1;
    end
endmodule

// File: rtl/e1pc_select.sv
// Priority resolver: picks one action for the current bit and forms the
// conditioned bit, tap flag and signaling nibble (combinational).
// Assumes the entry passed in belongs to the current timeslot.
module e1pc_select
    import e1pc_pkg::*;
(
    input  ts_cfg_t          cfg,
    input  logic             pc_en,
    input  logic             dir_extract,
    input  logic             unf_det,
    input  logic             unf_gen,
    input  logic             cas_en,
    input  logic [POS_W-1:0] bit_idx,
    input  logic [PH_W-1:0]  phase,
    input  logic             tx_bit,
    input  logic             loop_bit,
    input  logic             pat_bit,
    input  logic [SIG_W-1:0] sig_in,
    output logic             data_out,
    output logic             tap_vld,
    output logic [SIG_W-1:0] sig_out
);
    act_e              act;
    logic              tap_hit;
    logic              pat_hit;
    logic              flip;
    logic [SLOT_W-1:0] mwb;
    logic [POS_W-1:0]  msb_pos;

    // Decide whether the bit is tapped or overwritten by the pattern.
    always_comb begin
        tap_hit = pc_en && dir_extract && (unf_det || cfg.test);
        pat_hit = pc_en && !dir_extract && (unf_gen || cfg.test);
    end

    // Resolve the fixed priority order, highest first.
    always_comb begin
        if (!pc_en)                      act = ACT_PASS;
        else if (tap_hit)                act = ACT_TAP;
        else if (cfg.loop)               act = ACT_LOOP;
        else if (cfg.subs && cfg.code_a) act = ACT_MW;
        else if (pat_hit)                act = ACT_PAT;
        else if (cfg.subs)               act = ACT_IDLE;
        else if (cfg.code_a || cfg.code_b) act = ACT_INV;
        else                             act = ACT_PASS;
    end

    // Work out the milliwatt byte, bit index and inversion mask.
    always_comb begin
        mwb     = mw_byte(cfg.code_b, phase);
        msb_pos = ~bit_idx;
        flip    = (cfg.code_a && cfg.code_b)
               || (!cfg.code_a && cfg.code_b && !bit_idx[0])
               || (cfg.code_a && !cfg.code_b && bit_idx[0]);
    end

    // Form the outgoing bit from the chosen action.
    always_comb begin
        case (act)
            ACT_LOOP: data_out = loop_bit;
            ACT_MW:   data_out = mwb[msb_pos];
            ACT_PAT:  data_out = pat_bit;
            ACT_IDLE: data_out = cfg.idle[msb_pos];
            ACT_INV:  data_out = tx_bit ^ flip;
            default:  data_out = tx_bit;
        endcase
        tap_vld = (act == ACT_TAP);
    end

    // Substitute the stored nibble when signaling comes from the table.
    always_comb sig_out = (pc_en && cas_en && cfg.sigsrc) ? cfg.abcd : sig_in;
endmodule

// File: rtl/e1_tx_payload_cond.sv
// E1 per-timeslot transmit payload conditioner, top level. Looks up the
// current timeslot's entry, resolves the action and registers all outputs
// (one clock of latency). Assumes one bit per clock with its position given.
module e1_tx_payload_cond
    import e1pc_pkg::*;
#(
    parameter int N_TS = 32,
    localparam int TS_W = $clog2(N_TS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pc_en_i,
    input  logic              dir_extract_i,
    input  logic              unf_det_i,
    input  logic              unf_gen_i,
    input  logic              cas_en_i,
    input  logic              cfg_we_i,
    input  logic [TS_W-1:0]   cfg_ts_i,
    input  logic [CFG_W-1:0]  cfg_wdata_i,
    input  logic [TS_W-1:0]   ts_idx_i,
    input  logic [POS_W-1:0]  bit_idx_i,
    input  logic              tx_bit_i,
    input  logic              loop_bit_i,
    input  logic              pat_bit_i,
    input  logic [SIG_W-1:0]  sig_i,
    output logic              tx_bit_o,
    output logic [SIG_W-1:0]  sig_o,
    output logic              tap_vld_o,
    output logic              tap_bit_o
);
    ts_cfg_t          rd_cfg;
    logic [PH_W-1:0]  phase;
    logic             nxt_data;
    logic             nxt_tap;
    logic [SIG_W-1:0] nxt_sig;

    e1pc_cfg_store #(.N_TS(N_TS)) u_store (
        .clk (clk),
        .rst_n (rst_n),
        .we (cfg_we_i),
        .wa (cfg_ts_i),
        .wd (ts_cfg_t'(cfg_wdata_i)),
        .ra (ts_idx_i),
        .rd (rd_cfg)
    );

    e1pc_frame_phase #(.N_TS(N_TS)) u_phase (
        .clk (clk),
        .rst_n (rst_n),
        .ts_idx (ts_idx_i),
        .bit_idx (bit_idx_i),
        .phase (phase)
    );

    e1pc_select u_sel (
        .cfg (rd_cfg),
        .pc_en (pc_en_i),
        .dir_extract (dir_extract_i),
        .unf_det (unf_det_i),
        .unf_gen (unf_gen_i),
        .cas_en (cas_en_i),
        .bit_idx (bit_idx_i),
        .phase (phase),
        .tx_bit (tx_bit_i),
        .loop_bit (loop_bit_i),
        .pat_bit (pat_bit_i),
        .sig_in (sig_i),
        .data_out (nxt_data),
        .tap_vld (nxt_tap),
        .sig_out (nxt_sig)
    );

    // Register the conditioned outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_bit_o  <= 1'b0;
            sig_o     <= '0;
            tap_vld_o <= 1'b0;
            tap_bit_o <= 1'b0;
        end else begin
            tx_bit_o  <= nxt_data;
            sig_o     <= nxt_sig;
            tap_vld_o <= nxt_tap;
            tap_bit_o <= nxt_tap ? tx_bit_i : 1'b0;
        end
    end
endmodule

// File: rtl/e1pc_checker.sv
// Property checker for the payload conditioner, bound to the top level.
// Watches ports and the table entry read for the current timeslot.
module e1pc_checker
    import e1pc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             pc_en_i,
    input logic             dir_extract_i,
    input logic             cas_en_i,
    input logic             tx_bit_i,
    input logic             loop_bit_i,
    input logic [SIG_W-1:0] sig_i,
    input ts_cfg_t          rd_cfg,
    input logic             tx_bit_o,
    input logic [SIG_W-1:0] sig_o,
    input logic             tap_vld_o,
    input logic             tap_bit_o
);
    AST_OFF_PASSES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_en_i |=> (tx_bit_o == $past(tx_bit_i)) && (sig_o == $past(sig_i))); // R2
    AST_OFF_NO_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_en_i |=> !tap_vld_o); // R2
    AST_TAP_NEEDS_EXTRACT: assert property (@(posedge clk) disable iff (!rst_n)
        !(pc_en_i && dir_extract_i) |=> !tap_vld_o); // R3
    AST_TAP_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        tap_vld_o |-> (tap_bit_o == tx_bit_o)); // R3
    AST_LOOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_en_i && !dir_extract_i && rd_cfg.loop) |=> (tx_bit_o == $past(loop_bit_i))); // R4
    AST_SIG_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_en_i && cas_en_i && rd_cfg.sigsrc) |=> (sig_o == $past(rd_cfg.abcd))); // R9
endmodule

bind e1_tx_payload_cond e1pc_checker u_e1pc_checker (
    .clk (clk),
    .rst_n (rst_n),
    .pc_en_i (pc_en_i),
    .dir_extract_i (dir_extract_i),
    .cas_en_i (cas_en_i),
    .tx_bit_i (tx_bit_i),
    .loop_bit_i (loop_bit_i),
    .sig_i (sig_i),
    .rd_cfg (rd_cfg),
    .tx_bit_o (tx_bit_o),
    .sig_o (sig_o),
    .tap_vld_o (tap_vld_o),
    .tap_bit_o (tap_bit_o)
);

// File: tb/test_e1_tx_payload_cond.sv
module test_e1_tx_payload_cond;
    localparam int CLK_PERIOD = 10;
    localparam int NTS = 32;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic rst_n, pc_en_i, dir_extract_i, unf_det_i, unf_gen_i, cas_en_i, cfg_we_i;
    logic [4:0] cfg_ts_i, ts_idx_i;
    logic [17:0] cfg_wdata_i;
    logic [2:0] bit_idx_i;
    logic tx_bit_i, loop_bit_i, pat_bit_i, tx_bit_o, tap_vld_o, tap_bit_o;
    logic [3:0] sig_i, sig_o;

    e1_tx_payload_cond i_e1_tx_payload_cond (.*);

    int n_vec = 0, n_bad = 0;
    logic [17:0] shadow [NTS];
    int fcnt = 0, pos = 0;
    logic g_en = 0, g_dir = 0, g_ud = 0, g_ug = 0, g_cas = 0;
    logic pend = 0, e_bit, e_tv, e_tb;
    logic [3:0] e_sig;
    string e_tag;

    function automatic logic [7:0] ref_mw(input logic alaw, input int ph);
        logic [7:0] a [8] = '{8'h34, 8'h21, 8'h21, 8'h34, 8'hB4, 8'hA1, 8'hA1, 8'hB4};
        logic [7:0] u [8] = '{8'h1E, 8'h0B, 8'h0B, 8'h1E, 8'h9E, 8'h8B, 8'h8B, 8'h9E};
        return alaw ? a[ph] : u[ph];
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at pos %0d: got %b expected %b", tag, pos, act, exp);
        end
    endtask

    // Reference model for the bit being driven now (R2-R9, R11 layout).
    task automatic model(input int ts, input int bi, input logic tx, input logic lp, input logic pt, input logic [3:0] sg);
        logic [17:0] w = shadow[ts];
        logic subs = w[5], ca = w[4], cb = w[3], tst = w[2], lpb = w[1], ss = w[0];
        logic [7:0] idl = w[13:6];
        logic fl;
        e_tv = 0; e_tb = 0; e_bit = tx; e_tag = "R2";
        if (g_en) begin
            e_tag = "R8";
            if (g_dir && (g_ud || tst)) begin e_tv = 1; e_tb = tx; e_tag = "R3"; end
            else if (lpb) begin e_bit = lp; e_tag = "R4"; end
            else if (subs && ca) begin e_bit = ref_mw(cb, fcnt)[7-bi]; e_tag = "R5"; end
            else if (!g_dir && (g_ug || tst)) begin e_bit = pt; e_tag = "R6"; end
            else if (subs) begin e_bit = idl[7-bi]; e_tag = "R7"; end
            else begin
                fl = (ca && cb) || (!ca && cb && (bi % 2 == 0)) || (ca && !cb && (bi % 2 == 1));
                e_bit = tx ^ fl;
            end
        end
        e_sig = (g_en && g_cas && ss) ? w[17:14] : sg;
    endtask

    task automatic compare();
        if (pend) begin
            chk(tx_bit_o, e_bit, e_tag);
            chk(tap_vld_o, e_tv, "R3");
            chk(tap_bit_o, e_tb, "R3");
            n_vec++;
            if (sig_o !== e_sig) begin
                n_bad++;
                $display("FAIL R9 at pos %0d: got %h expected %h", pos, sig_o, e_sig);
            end
        end
    endtask

    // One bit: check the previous bit's outputs, drive the next (R10 latency).
    task automatic step(input logic we, input int wa, input logic [17:0] wd);
        @(negedge clk);
        compare();
        pc_en_i = g_en; dir_extract_i = g_dir; unf_det_i = g_ud; unf_gen_i = g_ug; cas_en_i = g_cas;
        ts_idx_i = 5'(pos / 8); bit_idx_i = 3'(pos % 8);
        tx_bit_i = 1'($urandom); loop_bit_i = 1'($urandom); pat_bit_i = 1'($urandom); sig_i = 4'($urandom);
        cfg_we_i = we; cfg_ts_i = 5'(wa); cfg_wdata_i = wd;
        model(pos / 8, pos % 8, tx_bit_i, loop_bit_i, pat_bit_i, sig_i);
        pend = 1;
        if (we) shadow[wa] = wd;
        if (pos == 255) fcnt = (fcnt + 1) % 8;
        pos = (pos + 1) % 256;
    endtask

    task automatic run_bits(input int n);
        for (int i = 0; i < n; i++) step(0, 0, '0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NTS; i++) shadow[i] = '0;
        rst_n = 0; pc_en_i = 0; dir_extract_i = 0; unf_det_i = 0; unf_gen_i = 0; cas_en_i = 0;
        cfg_we_i = 0; cfg_ts_i = 0; cfg_wdata_i = 0; ts_idx_i = 0; bit_idx_i = 0;
        tx_bit_i = 1; loop_bit_i = 1; pat_bit_i = 1; sig_i = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs cleared by reset
        chk(tx_bit_o, 0, "R1"); chk(tap_vld_o, 0, "R1"); chk(tap_bit_o, 0, "R1");
        chk(sig_o == 4'h0, 1, "R1");
        rst_n = 1;
        // R1: cleared table means no alteration (enable on, generate, framed)
        g_en = 1; g_cas = 1;
        run_bits(256);
        // R2: random table, enable off
        g_en = 0;
        for (int i = 0; i < NTS; i++) step(1, i, 18'($urandom));
        run_bits(256);
        // Random tables and globals, writes mid-stream (R3-R9, R11)
        for (int it = 0; it < 14; it++) begin
            {g_dir, g_ud, g_ug, g_cas} = 4'($urandom);
            g_en = ($urandom % 4) != 0;
            for (int i = 0; i < NTS; i++) begin
                logic [17:0] wd = 18'($urandom);
                if (it % 2 == 1) wd[2:1] = 2'b00; // expose milliwatt, idle, invert
                step(1, i, wd);
            end
            run_bits(200);
        end
        // R5/R10: milliwatt across nine frames, both laws
        g_en = 1; g_dir = 0; g_ud = 0; g_ug = 1; g_cas = 0;
        for (int i = 0; i < NTS; i++) step(1, i, {4'h0, 8'h00, 1'b1, 1'b1, 1'($urandom), 3'b000});
        run_bits(256 * 9);
        // R6/R7/R8: directed idle and inversion codes, framed pattern insert
        g_ug = 0;
        for (int i = 0; i < NTS; i++) step(1, i, {4'hA, 8'hC5, 1'(i % 4 == 0), 2'(i % 3 + 1), 1'(i % 5 == 0), 2'b00});
        run_bits(512);
        step(0, 0, '0);
        @(negedge clk);
        compare();
        summary();
        $finish;
    end
endmodule